// File: doc/BRIEF.md
# Parallel Flash Host Bus Front End

This block is the host-facing bus logic of an asynchronous parallel NOR flash device, rebuilt to run on a fast internal clock. It watches the three active-low strobes from the host (chip enable, output enable, write enable) through two-flop synchronisers. From them it decides when the data pins may drive, and it steers array read data onto the correct byte lane. It also captures command writes and hands them to the command decoder.

The device organisation is fixed while reset is held. One configuration pin selects a byte-wide bus (8 data pins) or a word-wide bus (16 data pins). In byte-wide mode the top data pin stops carrying data and becomes the least-significant address bit, picking the upper or lower byte. A command write is taken when chip enable and write enable are both low with output enable high. It is committed on whichever of chip enable or write enable rises first. The committed address and data appear on an internal interface together with a one-cycle valid pulse.

Top module: `flash_bus_if`

## Requirements
- R1: While output enable is high, every bit of `dqOe` is 0, from 3 clock cycles after output enable rises.
- R2: While chip enable is high, every bit of `dqOe` is 0 whatever output enable does, from 3 clock cycles after chip enable rises.
- R3: In word-wide mode, with chip enable and output enable both low, `dqOe` is 16'hFFFF and `dqOut` equals `rdData`. `dqOe` changes exactly 3 clock cycles after the later of the two strobes falls and still reads 0 one cycle before that.
- R4: The width mode comes from `widthSel` as sampled during the last clock edge with `rstN` low: 1 gives word-wide mode and 0 gives byte-wide mode. Changing `widthSel` after reset has no effect on `dqOe` or `dqOut`.
- R5: In byte-wide mode a read drives `dqOe` = 16'h00FF. `dqOut[7:0]` is `rdData[15:8]` when `dqIn[15]` is 1 and `rdData[7:0]` when it is 0, and `dqOut[15:8]` is 0.
- R6: A write cycle (chip enable low, write enable low, output enable high) that ends by write enable rising produces one single-cycle `cmdValid` pulse. The pulse appears exactly 3 clock cycles after the rise, provided address and data are held for at least 3 cycles after it.
- R7: When chip enable rises first and ends the write, the command is captured 3 cycles later. The later rise of write enable produces no second pulse.
- R8: No command is captured when output enable is low during the write, or when chip enable stays high while write enable pulses.
- R9: In word-wide mode a command gives `cmdAddr` = {`addrIn`, 1'b0} and `cmdData` = `dqIn`. In byte-wide mode it gives `cmdAddr` = {`addrIn`, `dqIn[15]`} and `cmdData` = {8'h00, `dqIn[7:0]`}.
- R10: While `rstN` is low and just after it rises, `dqOe`, `cmdValid`, `cmdAddr` and `cmdData` are all zero.
- R11: `cmdAddr` and `cmdData` keep their values except in the cycle where `cmdValid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rstN | input | 1 | Active-low power-up reset; width pin sampled while low |
| chipEnN | input | 1 | Asynchronous active-low chip enable strobe |
| outEnN | input | 1 | Asynchronous active-low output enable strobe |
| wrEnN | input | 1 | Asynchronous active-low write enable strobe |
| widthSel | input | 1 | Width configuration pin: 1 word-wide, 0 byte-wide |
| addrIn | input | ADDR_W | Host address pins |
| dqIn | input | DATA_W | Input side of the data pins (bit 15 is address LSB in byte mode) |
| rdData | input | DATA_W | Word read from the array |
| dqOut | output | DATA_W | Output side of the data pins |
| dqOe | output | DATA_W | Per-pin output driver enable |
| cmdValid | output | 1 | One-cycle pulse when a command is committed |
| cmdAddr | output | ADDR_W+1 | Captured command byte address |
| cmdData | output | DATA_W | Captured command data |

## Verification
Every strobe-driven result is due exactly 3 clock cycles after the host strobe changes: two synchroniser stages and then the output register. This holds both for the driver enables and for the command pulse. The bench changes inputs on the falling clock edge. It samples one cycle before the due cycle to confirm the old value is still present, then samples on the falling edge after the third rising edge to confirm the new one. The read data path is combinational from `rdData` and `dqIn[15]`, so it is checked in the same sample as the enables. Absent captures are counted by a pulse counter over a window of several cycles past the due cycle.

// File: rtl/flash_bus_pkg.sv
package flash_bus_pkg;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic readEn;      // chip and output enables both active
    logic shadowLoad;  // a legal write cycle is in progress
    logic cmdFire;     // write cycle just ended by CE or WE rising
  } strobes_t;

endpackage

// File: rtl/flash_bus_ctrl.sv
module flash_bus_ctrl
  import flash_bus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     chipEnN,
  input  logic     outEnN,
  input  logic     wrEnN,
  input  logic     widthSel,
  output logic     byteMode,
  output strobes_t strb
);

  localparam int NUM_STROBES = 3;
  localparam int LAST = SYNC_STAGES - 1;

  logic [NUM_STROBES-1:0] syncQ [SYNC_STAGES];

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[s] <= '1;
          else       syncQ[s] <= {chipEnN, outEnN, wrEnN};
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[s] <= '1;
          else       syncQ[s] <= syncQ[s-1];
        end
      end
    end
  endgenerate

  logic ceSync, oeSync, weSync;
  logic wrLive, wrLivePrev;

  assign ceSync = syncQ[LAST][2];
  assign oeSync = syncQ[LAST][1];
  assign weSync = syncQ[LAST][0];

  assign wrLive = !ceSync && !weSync && oeSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrLivePrev <= 1'b0;
    else       wrLivePrev <= wrLive;
  end

  // Width pin is taken only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) byteMode <= !widthSel;
  end

  always_comb begin
    strb.readEn     = !ceSync && !oeSync;
    strb.shadowLoad = wrLive;
    strb.cmdFire    = wrLivePrev && (ceSync || weSync);
  end

endmodule

// File: rtl/flash_bus_dp.sv
module flash_bus_dp
  import flash_bus_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic              byteMode,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dqIn,
  input  logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] dqOut,
  output logic [DATA_W-1:0] dqOe,
  output logic              cmdValid,
  output logic [ADDR_W:0]   cmdAddr,
  output logic [DATA_W-1:0] cmdData
);

  localparam int LANE_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] LOW_LANE = {{LANE_W{1'b0}}, {LANE_W{1'b1}}};

  logic            laneSel;
  logic [ADDR_W:0] shAddr;
  logic [DATA_W-1:0] shData;

  assign laneSel = dqIn[DATA_W-1];

  // Read steering toward the pins
  always_comb begin
    if (byteMode)
      dqOut = {{LANE_W{1'b0}}, laneSel ? rdData[DATA_W-1:LANE_W] : rdData[LANE_W-1:0]};
    else
      dqOut = rdData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dqOe <= '0;
    else if (strb.readEn) dqOe <= byteMode ? LOW_LANE : '1;
    else dqOe <= '0;
  end

  // Shadow follows the bus for the whole write cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shAddr <= '0;
      shData <= '0;
    end else if (strb.shadowLoad) begin
      shAddr <= byteMode ? {addrIn, laneSel} : {addrIn, 1'b0};
      shData <= byteMode ? {{LANE_W{1'b0}}, dqIn[LANE_W-1:0]} : dqIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      cmdAddr  <= '0;
      cmdData  <= '0;
    end else begin
      cmdValid <= strb.cmdFire;
      if (strb.cmdFire) begin
        cmdAddr <= shAddr;
        cmdData <= shData;
      end
    end
  end

endmodule

// File: rtl/flash_bus_if.sv
module flash_bus_if
  import flash_bus_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEnN,
  input  logic              outEnN,
  input  logic              wrEnN,
  input  logic              widthSel,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dqIn,
  input  logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] dqOut,
  output logic [DATA_W-1:0] dqOe,
  output logic              cmdValid,
  output logic [ADDR_W:0]   cmdAddr,
  output logic [DATA_W-1:0] cmdData
);

  strobes_t strb;
  logic     byteMode;

  flash_bus_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .outEnN(outEnN),
    .wrEnN(wrEnN), .widthSel(widthSel), .byteMode(byteMode), .strb(strb)
  );

  flash_bus_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .byteMode(byteMode),
    .addrIn(addrIn), .dqIn(dqIn), .rdData(rdData), .dqOut(dqOut),
    .dqOe(dqOe), .cmdValid(cmdValid), .cmdAddr(cmdAddr), .cmdData(cmdData)
  );

endmodule

// File: rtl/flash_bus_if_chk.sv
module flash_bus_if_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              chipEnN,
  input logic              outEnN,
  input logic [DATA_W-1:0] dqOe,
  input logic              cmdValid,
  input logic [ADDR_W:0]   cmdAddr,
  input logic [DATA_W-1:0] cmdData
);

  localparam int LANE_W = DATA_W / 2;

  logic [1:0] sinceRst;
  logic       armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end
  assign armed = (sinceRst == 2'd3);

  p_oe_hiz_r1: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(outEnN, 3)) |-> (dqOe == '0));

  p_deselect_hiz_r2: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(chipEnN, 3)) |-> (dqOe == '0));

  p_read_drive_r3: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(!chipEnN && !outEnN, 3)) |-> (dqOe != '0));

  p_upper_lane_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dqOe[DATA_W-1:LANE_W] != '0) |-> (&dqOe));

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  p_cmd_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !cmdValid) |-> ($stable(cmdAddr) && $stable(cmdData)));

endmodule

bind flash_bus_if flash_bus_if_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .outEnN(outEnN),
  .dqOe(dqOe), .cmdValid(cmdValid), .cmdAddr(cmdAddr), .cmdData(cmdData)
);

// File: tb/sim_flash_bus_if.sv
`timescale 1ns/1ps
module sim_flash_bus_if;

  localparam int ADDR_W = 19;
  localparam int DATA_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipEnN = 1'b1, outEnN = 1'b1, wrEnN = 1'b1, widthSel = 1'b1;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [DATA_W-1:0] dqIn = '0, rdData = '0;
  logic [DATA_W-1:0] dqOut, dqOe, cmdData;
  logic [ADDR_W:0]   cmdAddr;
  logic              cmdValid;

  int checks = 0, fails = 0, pulses = 0;
  bit done = 0;

  always #10 clk = ~clk;

  flash_bus_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .outEnN(outEnN), .wrEnN(wrEnN),
    .widthSel(widthSel), .addrIn(addrIn), .dqIn(dqIn), .rdData(rdData),
    .dqOut(dqOut), .dqOe(dqOe), .cmdValid(cmdValid), .cmdAddr(cmdAddr),
    .cmdData(cmdData)
  );

  always @(posedge clk) if (rstN && cmdValid) pulses++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset(input logic w);
    rstN = 1'b0; widthSel = w;
    chipEnN = 1'b1; outEnN = 1'b1; wrEnN = 1'b1;
    cyc(4);
    chk("R10 dqOe in reset", dqOe, 0);
    chk("R10 cmdValid in reset", cmdValid, 0);
    rstN = 1'b1;
    cyc(1);
    chk("R10 cmdAddr after reset", cmdAddr, 0);
    chk("R10 cmdData after reset", cmdData, 0);
  endtask

  task automatic tReadWord();
    rdData = 16'hA5C3;
    chipEnN = 1'b0; outEnN = 1'b0;
    cyc(2);
    chk("R3 dqOe before due cycle", dqOe, 0);
    cyc(1);
    chk("R3 dqOe word read", dqOe, 16'hFFFF);
    chk("R3 dqOut word read", dqOut, 16'hA5C3);
    outEnN = 1'b1;
    cyc(3);
    chk("R1 dqOe with OE high", dqOe, 0);
    outEnN = 1'b0; chipEnN = 1'b1;
    cyc(3);
    chk("R2 dqOe deselected, OE low", dqOe, 0);
  endtask

  task automatic tWriteWe(input logic [ADDR_W-1:0] a, input logic [15:0] d,
                          input logic [ADDR_W:0] expA, input logic [15:0] expD, input string req);
    chipEnN = 1'b0; outEnN = 1'b1; addrIn = a; dqIn = d; wrEnN = 1'b0;
    cyc(4);
    wrEnN = 1'b1;
    cyc(2);
    chk("R6 cmdValid before due cycle", cmdValid, 0);
    cyc(1);
    chk("R6 cmdValid on due cycle", cmdValid, 1);
    chk({req, " cmdAddr"}, cmdAddr, expA);
    chk({req, " cmdData"}, cmdData, expD);
    cyc(1);
    chk("R6 cmdValid one cycle only", cmdValid, 0);
    chipEnN = 1'b1;
    cyc(3);
  endtask

  task automatic tWriteCeFirst();
    int p0;
    p0 = pulses;
    outEnN = 1'b1; addrIn = 19'h12345; dqIn = 16'h0F0F;
    wrEnN = 1'b0; chipEnN = 1'b0;
    cyc(4);
    chipEnN = 1'b1;
    cyc(3);
    chk("R7 capture on CE rise", cmdValid, 1);
    chk("R7 cmdData on CE rise", cmdData, 16'h0F0F);
    cyc(2);
    wrEnN = 1'b1;
    cyc(6);
    chk("R7 no second pulse on WE rise", pulses - p0, 1);
  endtask

  task automatic tNoCapture();
    int p0;
    logic [ADDR_W:0] a0;
    p0 = pulses; a0 = cmdAddr;
    addrIn = 19'h7FFFF; dqIn = 16'hDEAD;
    chipEnN = 1'b0; outEnN = 1'b0; wrEnN = 1'b0;
    cyc(4);
    wrEnN = 1'b1; chipEnN = 1'b1;
    cyc(6);
    chk("R8 no pulse with OE low", pulses - p0, 0);
    outEnN = 1'b1;
    wrEnN = 1'b0;
    cyc(4);
    wrEnN = 1'b1;
    cyc(6);
    chk("R8 no pulse with CE high", pulses - p0, 0);
    chk("R8 cmdAddr unchanged", cmdAddr, a0);
  endtask

  task automatic tWidthLate();
    widthSel = 1'b0;
    rdData = 16'h3C5A;
    chipEnN = 1'b0; outEnN = 1'b0; dqIn = 16'h8000;
    cyc(3);
    chk("R4 late width change ignored, dqOe", dqOe, 16'hFFFF);
    chk("R4 late width change ignored, dqOut", dqOut, 16'h3C5A);
    chipEnN = 1'b1; outEnN = 1'b1;
    cyc(3);
  endtask

  task automatic tReadByte();
    rdData = 16'hB7E1;
    dqIn = 16'h0000;
    chipEnN = 1'b0; outEnN = 1'b0;
    cyc(3);
    chk("R4 byte mode from reset, dqOe", dqOe, 16'h00FF);
    chk("R5 low byte", dqOut, 16'h00E1);
    dqIn = 16'h8000;
    #1;
    chk("R5 high byte", dqOut, 16'h00B7);
    outEnN = 1'b1;
    cyc(3);
    chk("R1 byte mode OE high", dqOe, 0);
    chipEnN = 1'b1;
    cyc(2);
  endtask

  initial begin
    doReset(1'b1);
    tReadWord();
    tWriteWe(19'h5A3C1, 16'hBEEF, {19'h5A3C1, 1'b0}, 16'hBEEF, "R9 word");
    tWriteCeFirst();
    tNoCapture();
    tWidthLate();
    doReset(1'b0);
    tReadByte();
    tWriteWe(19'h00ABC, 16'h8077, {19'h00ABC, 1'b1}, 16'h0077, "R9 byte hi");
    tWriteWe(19'h40001, 16'h7F42, {19'h40001, 1'b0}, 16'h0042, "R9 byte lo");
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule